// File: doc/BRIEF.md
# Timer Request Pulse Generator with End-of-Interrupt Re-arm

This block sits between a general-purpose timer core and a DMA controller or interrupt controller. The timer core reports three kinds of event: counter overflow, compare match and input capture. Each event sets a latched status flag. A per-flag enable decides whether a pending flag counts toward the block's requests. Whenever at least one enabled flag is pending and the block is armed, it raises a request line for exactly one clock cycle. It then disarms itself.

While disarmed the block sends no further pulse, but new timer events still latch into the status flags. Software, or a chained DMA transfer, re-arms it by writing the end-of-interrupt register. The value written there is ignored. The intended service sequence is to clear the flags first (write 1 to clear) and then write end-of-interrupt. If end-of-interrupt is written while an enabled flag is still pending, a new pulse is issued at once. A level interrupt output follows the enabled pending flags and does not depend on the arming state.

Top module: `tmr_evt_req`

## Requirements
- R1: The status register sits at address 0 and holds three flags: bit 0 compare match, bit 1 overflow, bit 2 capture. Reading address 0 returns these raw flags, zero-extended, whatever the enable setting. A flag sets on the clock edge that samples its `evt_i` bit high.
- R2: A write to address 0 clears each flag whose data bit is 1 (writing 0x07 clears all three). A data bit of 0 leaves its flag unchanged.
- R3: After a request pulse, `req_pulse_o` stays low until the end-of-interrupt register is written, even if new events set flags.
- R4: A write to address 2 (end-of-interrupt) re-arms the pulse logic, whatever data value is written.
- R5: If an enabled flag is pending when end-of-interrupt is written, `req_pulse_o` is high in the cycle that follows that write's clock edge.
- R6: Clearing the flags before writing end-of-interrupt produces no extra pulse. Writing end-of-interrupt before clearing produces one extra pulse.
- R7: Events that arrive while the block is disarmed latch and stay set until they are cleared.
- R8: A request pulse is one clock cycle wide. It appears in the first cycle in which the block is armed and some enabled flag is pending.
- R9: The enable register at address 1 (bit i enables status bit i) masks each flag for both the pulse and the level output. It reads back at address 1.
- R10: `irq_level_o` is high exactly while some enabled flag is pending, regardless of the arming state.
- R11: An event and a clearing write to the same flag in the same cycle leave the flag set.
- R12: After reset all flags and enables are 0, the block is armed, both outputs are low, and address 2 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 3 | Timer events: bit 0 match, bit 1 overflow, bit 2 capture |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 status, 1 enable, 2 end-of-interrupt |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational on `reg_addr_i`) |
| req_pulse_o | output | 1 | Single-cycle request to the DMA or interrupt controller |
| irq_level_o | output | 1 | Level interrupt: some enabled flag is pending |

## Verification
Events, writes and end-of-interrupt all take effect on the next clock edge. Both outputs are decoded from registers, so a stimulus driven in one cycle shows on `req_pulse_o`, `irq_level_o` and the status read in the cycle right after that edge. Disarming takes effect one edge later, so the pulse is gone in the second cycle. The bench drives each stimulus on a falling edge and checks the outputs on the next falling edge. It then switches the address to the status register and reads it before driving the next stimulus, so every result is sampled in the cycle where it is due.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int NUM_FLAGS  = 3;
  localparam int FLAG_MATCH = 0;
  localparam int FLAG_OVF   = 1;
  localparam int FLAG_CAPT  = 2;

  localparam int ADDR_STATUS = 0;
  localparam int ADDR_ENABLE = 1;
  localparam int ADDR_EOI    = 2;

  // New flag value: write-1-clear, but a same-cycle event wins
  function automatic logic [NUM_FLAGS-1:0] flag_next(
    input logic [NUM_FLAGS-1:0] cur,
    input logic [NUM_FLAGS-1:0] clr,
    input logic [NUM_FLAGS-1:0] set
  );
    return (cur & ~clr) | set;
  endfunction

  // Any flag that is both latched and enabled
  function automatic logic pend_any(
    input logic [NUM_FLAGS-1:0] stat,
    input logic [NUM_FLAGS-1:0] en
  );
    return |(stat & en);
  endfunction
endpackage

// File: rtl/tmr_evt_regdec.sv
module tmr_evt_regdec
  import tmr_evt_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [NUM_FLAGS-1:0] status_i,
  input  logic [NUM_FLAGS-1:0] enable_i,
  output logic [NUM_FLAGS-1:0] clr_mask_o,
  output logic                 en_we_o,
  output logic [NUM_FLAGS-1:0] en_wdata_o,
  output logic                 eoi_we_o,
  output logic [DATA_W-1:0]    rdata_o
);
  localparam int PAD_W = DATA_W - NUM_FLAGS;

  logic sel_status, sel_enable, sel_eoi;
  logic unused_wdata_hi;

  assign sel_status = (addr_i == ADDR_W'(ADDR_STATUS));
  assign sel_enable = (addr_i == ADDR_W'(ADDR_ENABLE));
  assign sel_eoi    = (addr_i == ADDR_W'(ADDR_EOI));

  assign clr_mask_o = (wr_i && sel_status) ? wdata_i[NUM_FLAGS-1:0] : '0;
  assign en_we_o    = wr_i && sel_enable;
  assign en_wdata_o = wdata_i[NUM_FLAGS-1:0];
  assign eoi_we_o   = wr_i && sel_eoi;
  assign unused_wdata_hi = ^wdata_i[DATA_W-1:NUM_FLAGS];

  always_comb begin
    rdata_o = '0;
    if (sel_status)      rdata_o = {{PAD_W{1'b0}}, status_i};
    else if (sel_enable) rdata_o = {{PAD_W{1'b0}}, enable_i};
  end
endmodule

// File: rtl/tmr_evt_status.sv
module tmr_evt_status
  import tmr_evt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] evt_i,
  input  logic [NUM_FLAGS-1:0] clr_mask_i,
  input  logic                 en_we_i,
  input  logic [NUM_FLAGS-1:0] en_wdata_i,
  output logic [NUM_FLAGS-1:0] status_o,
  output logic [NUM_FLAGS-1:0] enable_o,
  output logic                 pend_o
);
  logic [NUM_FLAGS-1:0] status_q, enable_q, status_d;

  assign status_d = flag_next(status_q, clr_mask_i, evt_i);

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        status_q[g] <= 1'b0;
        enable_q[g] <= 1'b0;
      end else begin
        status_q[g] <= status_d[g];
        if (en_we_i) enable_q[g] <= en_wdata_i[g];
      end
    end

    // R11: an event always latches, even against a clearing write
    assert_evt_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[g] |=> status_q[g]);
    // R2: a flag with no event and no clear bit holds its value
    assert_zero_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_i[g] && !clr_mask_i[g]) |=> $stable(status_q[g]));
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign pend_o   = pend_any(status_q, enable_q);
endmodule

// File: rtl/tmr_evt_arm.sv
module tmr_evt_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_i,
  input  logic eoi_we_i,
  output logic pulse_o,
  output logic armed_o
);
  logic armed_q;
  logic fire;

  assign fire = armed_q && pend_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b1;
    else if (eoi_we_i) armed_q <= 1'b1;
    else if (fire)     armed_q <= 1'b0;
  end

  assign pulse_o = fire;
  assign armed_o = armed_q;

  // R3 / R8: a pulse is never followed by another unless EOI was written
  assert_lockout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && !eoi_we_i) |=> !pulse_o);
  // R4: an EOI write always leaves the logic armed
  assert_rearm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_we_i |=> armed_q);
endmodule

// File: rtl/tmr_evt_req.sv
module tmr_evt_req
  import tmr_evt_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] evt_i,
  input  logic                 reg_wr_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic                 req_pulse_o,
  output logic                 irq_level_o
);
  logic [NUM_FLAGS-1:0] clr_mask, en_wdata, status, enable;
  logic en_we, eoi_we, pend, armed;

  tmr_evt_regdec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .status_i(status), .enable_i(enable),
    .clr_mask_o(clr_mask), .en_we_o(en_we), .en_wdata_o(en_wdata),
    .eoi_we_o(eoi_we), .rdata_o(reg_rdata_o)
  );

  tmr_evt_status u_stat (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_mask_i(clr_mask),
    .en_we_i(en_we), .en_wdata_i(en_wdata),
    .status_o(status), .enable_o(enable), .pend_o(pend)
  );

  tmr_evt_arm u_arm (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .eoi_we_i(eoi_we),
    .pulse_o(req_pulse_o), .armed_o(armed)
  );

  assign irq_level_o = pend;

  // R5: EOI written while a request stays pending fires at once
  assert_eoi_refire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_we ##1 irq_level_o |-> req_pulse_o);
  // R10: a pulse is only ever issued while the level output is high
  assert_pulse_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse_o |-> irq_level_o);
  // R8: no pulse while disarmed
  assert_pulse_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse_o |-> armed);
endmodule

// File: tb/tb_tmr_evt_req.sv
module tb_tmr_evt_req;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] evt = '0;
  logic       wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pulse, irq;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tmr_evt_req dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .req_pulse_o(pulse),
    .irq_level_o(irq)
  );

  // Vector: {evt[3], wr, addr[2], wdata[8], exp_status[3], exp_irq, exp_pulse}
  localparam int NV = 17;
  localparam logic [18:0] VEC [NV] = '{
    {3'b000, 1'b1, 2'd1, 8'h07, 3'b000, 1'b0, 1'b0}, // enable all
    {3'b010, 1'b0, 2'd0, 8'h00, 3'b010, 1'b1, 1'b1}, // overflow -> pulse
    {3'b000, 1'b0, 2'd0, 8'h00, 3'b010, 1'b1, 1'b0}, // locked out
    {3'b001, 1'b0, 2'd0, 8'h00, 3'b011, 1'b1, 1'b0}, // match latches, no pulse
    {3'b000, 1'b1, 2'd0, 8'h07, 3'b000, 1'b0, 1'b0}, // clear all
    {3'b000, 1'b1, 2'd2, 8'h00, 3'b000, 1'b0, 1'b0}, // EOI, nothing pending
    {3'b100, 1'b0, 2'd0, 8'h00, 3'b100, 1'b1, 1'b1}, // capture -> pulse
    {3'b000, 1'b0, 2'd0, 8'h00, 3'b100, 1'b1, 1'b0},
    {3'b000, 1'b1, 2'd2, 8'h5A, 3'b100, 1'b1, 1'b1}, // EOI before clear: extra
    {3'b000, 1'b1, 2'd0, 8'h04, 3'b000, 1'b0, 1'b0},
    {3'b000, 1'b1, 2'd2, 8'hFF, 3'b000, 1'b0, 1'b0},
    {3'b000, 1'b1, 2'd1, 8'h02, 3'b000, 1'b0, 1'b0}, // enable overflow only
    {3'b001, 1'b0, 2'd0, 8'h00, 3'b001, 1'b0, 1'b0}, // masked match
    {3'b000, 1'b1, 2'd0, 8'h00, 3'b001, 1'b0, 1'b0}, // write 0: no change
    {3'b010, 1'b1, 2'd0, 8'h02, 3'b011, 1'b1, 1'b1}, // event beats clear
    {3'b000, 1'b1, 2'd0, 8'h03, 3'b000, 1'b0, 1'b0},
    {3'b000, 1'b1, 2'd2, 8'h00, 3'b000, 1'b0, 1'b0}
  };
  localparam string VREQ [NV] = '{
    "R9", "R8", "R3", "R7", "R2", "R6", "R8", "R3", "R5", "R6", "R4",
    "R9", "R9", "R2", "R11", "R2", "R6"
  };

  task automatic check(input string req, input int act, input int exp_v);
    n_run++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp_v, $time);
    end
  endtask

  task automatic read_status(input string req, input int exp_v);
    wr = 1'b0; addr = 2'd0; evt = '0;
    #1 check(req, int'(rdata), exp_v);
  endtask

  task automatic drive(input logic [2:0] e, input logic w, input logic [1:0] a,
                       input logic [7:0] d);
    evt = e; wr = w; addr = a; wdata = d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", int'(pulse), 0);
    check("R12", int'(irq), 0);
    read_status("R12", 0);
    addr = 2'd1; #1 check("R12", int'(rdata), 0);
    addr = 2'd2; #1 check("R12", int'(rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][18:16], VEC[i][15], VEC[i][14:13], VEC[i][12:5]);
      @(negedge clk);
      check(VREQ[i], int'(irq), int'(VEC[i][1]));
      check(VREQ[i], int'(pulse), int'(VEC[i][0]));
      read_status(VREQ[i], int'(VEC[i][4:2]));
    end

    // R9: all enables off, raw flags still read back, outputs quiet
    drive(3'b000, 1'b1, 2'd1, 8'h00); @(negedge clk);
    drive(3'b111, 1'b0, 2'd0, 8'h00); @(negedge clk);
    check("R9", int'(irq), 0);
    check("R9", int'(pulse), 0);
    read_status("R1", 7);
    addr = 2'd1; #1 check("R9", int'(rdata), 0);
    // R10: enabling a pending flag raises level and pulse; level outlives lockout
    drive(3'b000, 1'b1, 2'd1, 8'h01); @(negedge clk);
    check("R10", int'(irq), 1);
    check("R8", int'(pulse), 1);
    drive(3'b000, 1'b0, 2'd0, 8'h00); @(negedge clk);
    check("R10", int'(irq), 1);
    check("R3", int'(pulse), 0);
    // R6: proper order — clear, then EOI — gives no extra pulse
    drive(3'b000, 1'b1, 2'd0, 8'h07); @(negedge clk);
    check("R10", int'(irq), 0);
    drive(3'b000, 1'b1, 2'd2, 8'h00); @(negedge clk);
    check("R6", int'(pulse), 0);
    drive(3'b000, 1'b0, 2'd0, 8'h00); @(negedge clk);
    check("R6", int'(pulse), 0);

    // R12: reset mid-run restores the idle state
    drive(3'b111, 1'b1, 2'd1, 8'h07); @(negedge clk);
    drive(3'b000, 1'b0, 2'd0, 8'h00);
    rst_n = 1'b0; #1;
    check("R12", int'(irq), 0);
    check("R12", int'(pulse), 0);
    read_status("R12", 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R12: armed after reset — first enabled event pulses at once
    drive(3'b000, 1'b1, 2'd1, 8'h04); @(negedge clk);
    drive(3'b100, 1'b0, 2'd0, 8'h00); @(negedge clk);
    check("R12", int'(pulse), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule